// File: doc/BRIEF.md
# Nonvolatile Shadow Store/Recall Sequencer

This block sequences a shadowed SRAM whose contents are copied into a nonvolatile array before power is lost and copied back after power returns. It watches three inputs: a supply-good level from an external comparator, the SRAM write strobe and a hardware store request. From these it drives a store strobe and a recall strobe to the nonvolatile array, an access inhibit to the SRAM port, and an active-low busy line with a separate drive enable. When the drive enable is low, the busy pin is left to an external pull-up.

A dirty flag records whether any accepted SRAM write has happened since the last completed store or recall. A store request, whether it comes from a supply drop or from the hardware request pin, starts a store only when that flag is set. Before the store begins, writes stay open for a short grace window. All durations are parameters counted in clock cycles. The interface has no data stream, so every pin is a plain level with no valid/ready handshake and no back-pressure.

Top module: `nv_shadow_sequencer`

## Requirements
- R1: While reset is high, and on the first cycle after it, the block is in its power-low state: store_active=0, recall_active=0, access_inhibit=1, busy_drive=1, busy_n=0.
- R2: When supply_ok is high in the power-low state, recall_active goes high at the next clock edge and stays high for exactly RECALL_CYC cycles.
- R3: A store holds store_active high for exactly STORE_CYC cycles.
- R4: A store that is started first passes through a grace window of exactly GRACE_CYC cycles. In that window busy is driven low and access_inhibit is 0, even when supply_ok is low.
- R5: If the dirty flag is clear, a hardware store request is ignored: store_active stays 0 and busy_drive stays 0. If the flag is clear and the supply drops while the block is idle, the block goes straight to the power-low state without storing.
- R6: access_inhibit is 1 during a store, during a recall, in the power-low state, and whenever supply_ok is low outside the grace window. A write strobe given while access_inhibit is 1 is ignored.
- R7: When a store or recall completes with the supply good, busy is driven high (busy_drive=1, busy_n=1) for exactly RELEASE_CYC cycles. After that, busy_drive drops to 0.
- R8: For the whole of a store and of a recall, busy_drive=1 and busy_n=0. Store and recall are never active together.
- R9: A supply drop while dirty starts a store through the grace window. When the store ends, the block enters the power-low state. A new full-length recall follows once supply_ok is high.
- R10: A hardware store request that arrives during a store does not lengthen that store and is not held for later.
- R11: The dirty flag is set by an accepted write, including a write during the grace window or the busy-high phase. It is cleared when a store or recall completes. An inhibited write does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above the switch threshold |
| wr_strobe | input | 1 | SRAM write strobe, one per write cycle |
| hw_store_req | input | 1 | Hardware store request |
| store_active | output | 1 | Nonvolatile array is being written |
| recall_active | output | 1 | Nonvolatile array is being read back |
| access_inhibit | output | 1 | SRAM reads and writes are ignored |
| busy_n | output | 1 | Busy level, low while the device is busy |
| busy_drive | output | 1 | 1 when busy_n is actively driven, 0 when released |

## Verification
A store request is tried in four dirty-flag histories:
- no write at all;
- a write while idle;
- a write inside a store, where it is inhibited;
- a write during the busy-high phase.

Together these separate a store that is skipped from one that is performed. They also show whether an inhibited write leaks into the dirty flag. The supply is dropped both when the flag is clear and when it is set. This separates the direct path to power-low from the brown-out path, which runs grace, then store, then recall. The length of each phase is measured against its parameter, and a second request injected during a store shows whether it stretches the store or gets queued.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  typedef enum logic [2:0] {
    ST_POWER_LOW    = 3'd0,
    ST_IDLE         = 3'd1,
    ST_WRITE_GRACE  = 3'd2,
    ST_STORE        = 3'd3,
    ST_RECALL       = 3'd4,
    ST_RELEASE_HOLD = 3'd5
  } seq_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  // Loading N-1 on entry keeps the owning state for N cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/nvseq_dirty.sv
module nvseq_dirty (
  input  logic clk,
  input  logic rst,
  input  logic wr_strobe,
  input  logic access_inhibit,
  input  logic clear,
  output logic dirty
);

  logic dirty_q;

  // Clear and an accepted write never coincide: both ends of an operation are inhibited
  always_ff @(posedge clk) begin
    if (rst) begin
      dirty_q <= 1'b0;
    end else if (clear) begin
      dirty_q <= 1'b0;
    end else if (wr_strobe && !access_inhibit) begin
      dirty_q <= 1'b1;
    end
  end

  assign dirty = dirty_q;

endmodule

// File: rtl/nvseq_fsm.sv
module nvseq_fsm
  import nvseq_pkg::*;
#(
  parameter int unsigned RECALL_CYC  = 2000000,
  parameter int unsigned STORE_CYC   = 800000,
  parameter int unsigned GRACE_CYC   = 3,
  parameter int unsigned RELEASE_CYC = 50,
  parameter int unsigned CW          = 21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          supply_ok,
  input  logic          hw_store_req,
  input  logic          dirty,
  input  logic          tmr_expired,
  output seq_state_t    state,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          dirty_clr
);

  localparam logic [CW-1:0] RECALL_LD  = CW'(RECALL_CYC - 1);
  localparam logic [CW-1:0] STORE_LD   = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] GRACE_LD   = CW'(GRACE_CYC - 1);
  localparam logic [CW-1:0] RELEASE_LD = CW'(RELEASE_CYC - 1);

  seq_state_t state_q, state_d;
  logic       auto_q, auto_d;

  always_comb begin
    state_d   = state_q;
    auto_d    = auto_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    dirty_clr = 1'b0;
    unique case (state_q)
      ST_POWER_LOW: begin
        if (supply_ok) begin
          state_d  = ST_RECALL;
          tmr_load = 1'b1;
          tmr_val  = RECALL_LD;
        end
      end
      ST_RECALL: begin
        if (!supply_ok) begin
          state_d = ST_POWER_LOW;
        end else if (tmr_expired) begin
          state_d   = ST_RELEASE_HOLD;
          tmr_load  = 1'b1;
          tmr_val   = RELEASE_LD;
          dirty_clr = 1'b1;
        end
      end
      ST_IDLE: begin
        if (!supply_ok) begin
          if (dirty) begin
            state_d  = ST_WRITE_GRACE;
            auto_d   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = GRACE_LD;
          end else begin
            state_d = ST_POWER_LOW;
          end
        end else if (hw_store_req && dirty) begin
          state_d  = ST_WRITE_GRACE;
          auto_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = GRACE_LD;
        end
      end
      ST_WRITE_GRACE: begin
        if (tmr_expired) begin
          state_d  = ST_STORE;
          tmr_load = 1'b1;
          tmr_val  = STORE_LD;
        end
      end
      ST_STORE: begin
        if (tmr_expired) begin
          dirty_clr = 1'b1;
          if (!supply_ok || auto_q) begin
            state_d = ST_POWER_LOW;
          end else begin
            state_d  = ST_RELEASE_HOLD;
            tmr_load = 1'b1;
            tmr_val  = RELEASE_LD;
          end
        end
      end
      ST_RELEASE_HOLD: begin
        if (tmr_expired) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_POWER_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_POWER_LOW;
      auto_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      auto_q  <= auto_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/nv_shadow_sequencer.sv
module nv_shadow_sequencer
  import nvseq_pkg::*;
#(
  parameter int unsigned RECALL_CYC  = 2000000,
  parameter int unsigned STORE_CYC   = 800000,
  parameter int unsigned GRACE_CYC   = 3,
  parameter int unsigned RELEASE_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic wr_strobe,
  input  logic hw_store_req,
  output logic store_active,
  output logic recall_active,
  output logic access_inhibit,
  output logic busy_n,
  output logic busy_drive
);

  localparam int unsigned MAX_DUR = max2(max2(RECALL_CYC, STORE_CYC), max2(GRACE_CYC, RELEASE_CYC));
  localparam int unsigned CW      = $clog2(MAX_DUR + 1);

  seq_state_t    state;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;
  logic          dirty;
  logic          dirty_clr;

  nvseq_fsm #(
    .RECALL_CYC (RECALL_CYC),
    .STORE_CYC  (STORE_CYC),
    .GRACE_CYC  (GRACE_CYC),
    .RELEASE_CYC(RELEASE_CYC),
    .CW         (CW)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .supply_ok   (supply_ok),
    .hw_store_req(hw_store_req),
    .dirty       (dirty),
    .tmr_expired (tmr_expired),
    .state       (state),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .dirty_clr   (dirty_clr)
  );

  nvseq_timer #(
    .CW(CW)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  nvseq_dirty u_dirty (
    .clk           (clk),
    .rst           (rst),
    .wr_strobe     (wr_strobe),
    .access_inhibit(access_inhibit),
    .clear         (dirty_clr),
    .dirty         (dirty)
  );

  logic port_open;

  always_comb begin
    store_active  = (state == ST_STORE);
    recall_active = (state == ST_RECALL);
    busy_drive    = (state != ST_IDLE);
    busy_n        = (state == ST_IDLE) || (state == ST_RELEASE_HOLD);
    port_open     = (state == ST_WRITE_GRACE) ||
                    (supply_ok && ((state == ST_IDLE) || (state == ST_RELEASE_HOLD)));
    access_inhibit = !port_open;
  end

endmodule

// File: rtl/nvseq_checker.sv
module nvseq_checker (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic hw_store_req,
  input logic store_active,
  input logic recall_active,
  input logic access_inhibit,
  input logic busy_n,
  input logic busy_drive
);

  // R1: the cycle after reset shows the power-low outputs
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (busy_drive && !busy_n && access_inhibit && !store_active && !recall_active));

  // R2: a recall only begins after the supply was good
  assert_recall_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(recall_active) |-> $past(supply_ok));

  // R4: every store is entered from the open grace window
  assert_grace_before_store_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(store_active) |-> $past(!access_inhibit && busy_drive && !busy_n));

  // R6: the port is closed while the array is busy
  assert_op_inhibit_R6: assert property (@(posedge clk) disable iff (rst)
    (store_active || recall_active) |-> access_inhibit);

  // R6: low supply closes the port outside the grace window
  assert_supply_low_inhibit_R6: assert property (@(posedge clk) disable iff (rst)
    (!supply_ok && busy_n) |-> access_inhibit);

  // R7: busy is released only after it was driven high
  assert_release_after_high_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_drive) |-> $past(busy_n));

  // R8: busy held low during any array operation
  assert_op_busy_low_R8: assert property (@(posedge clk) disable iff (rst)
    (store_active || recall_active) |-> (busy_drive && !busy_n));

  // R8: store and recall are exclusive
  assert_exclusive_ops_R8: assert property (@(posedge clk) disable iff (rst)
    !(store_active && recall_active));

  // R10: a request during a store never restarts the grace window
  assert_no_requeue_R10: assert property (@(posedge clk) disable iff (rst)
    (store_active && hw_store_req && supply_ok) |=> (store_active || busy_n || !busy_drive || recall_active || access_inhibit));

endmodule

bind nv_shadow_sequencer nvseq_checker u_nvseq_checker (.*);

// File: tb/nv_shadow_sequencer_bench.sv
module nv_shadow_sequencer_bench;

  localparam int unsigned T_RECALL  = 7;
  localparam int unsigned T_STORE   = 5;
  localparam int unsigned T_GRACE   = 3;
  localparam int unsigned T_RELEASE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic wr_strobe = 1'b0;
  logic hw_store_req = 1'b0;
  logic store_active, recall_active, access_inhibit, busy_n, busy_drive;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nv_shadow_sequencer #(
    .RECALL_CYC (T_RECALL),
    .STORE_CYC  (T_STORE),
    .GRACE_CYC  (T_GRACE),
    .RELEASE_CYC(T_RELEASE)
  ) u_nv_shadow_sequencer (
    .clk           (clk),
    .rst           (rst),
    .supply_ok     (supply_ok),
    .wr_strobe     (wr_strobe),
    .hw_store_req  (hw_store_req),
    .store_active  (store_active),
    .recall_active (recall_active),
    .access_inhibit(access_inhibit),
    .busy_n        (busy_n),
    .busy_drive    (busy_drive)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 recall, 1 store, 2 grace, 3 busy-high, 4 power-low
  function automatic bit probe(input int sel);
    case (sel)
      0: return recall_active;
      1: return store_active;
      2: return busy_drive && !busy_n && !access_inhibit && !store_active && !recall_active;
      3: return busy_drive && busy_n;
      default: return busy_drive && !busy_n && access_inhibit && !store_active && !recall_active;
    endcase
  endfunction

  task automatic run_len(input int sel, output int len);
    int guard;
    guard = 0;
    len = 0;
    while (!probe(sel) && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    while (probe(sel) && len < 40) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_write();
    wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic pulse_req();
    hw_store_req = 1'b1;
    @(negedge clk);
    hw_store_req = 1'b0;
  endtask

  task automatic quiet_window(input string req, input int cycles);
    int seen;
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      if (store_active || busy_drive) seen++;
      @(negedge clk);
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    int len;
    repeat (3) @(negedge clk);
    // R1: reset state during and after reset
    check(busy_drive && !busy_n && access_inhibit && !store_active && !recall_active,
          "R1 in reset", {busy_drive, busy_n, access_inhibit}, 3'b101);
    rst = 1'b0;
    @(negedge clk);
    check(busy_drive && !busy_n && access_inhibit && !store_active && !recall_active,
          "R1 after reset", {busy_drive, busy_n, access_inhibit}, 3'b101);

    // R2 power-up recall
    supply_ok = 1'b1;
    @(negedge clk);
    check(recall_active == 1'b1, "R2 recall starts next edge", recall_active, 1);
    check(busy_drive && !busy_n, "R8 busy low in recall", busy_n, 0);
    check(access_inhibit == 1'b1, "R6 inhibit in recall", access_inhibit, 1);
    run_len(0, len);
    check(len == T_RECALL, "R2 recall length", len, T_RECALL);
    run_len(3, len);
    check(len == T_RELEASE, "R7 busy-high after recall", len, T_RELEASE);
    check(busy_drive == 1'b0, "R7 released", busy_drive, 0);

    // R5 clean request is ignored
    pulse_req();
    quiet_window("R5 clean request skipped", 12);

    // R3 R4 R10 dirty request with a second request and an inhibited write inside the store
    pulse_write();
    pulse_req();
    run_len(2, len);
    check(len == T_GRACE, "R4 grace length", len, T_GRACE);
    check(store_active == 1'b1, "R3 store follows grace", store_active, 1);
    wr_strobe = 1'b1;
    hw_store_req = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
    hw_store_req = 1'b0;
    run_len(1, len);
    check(len + 1 == T_STORE, "R3 R10 store length", len + 1, T_STORE);
    run_len(3, len);
    check(len == T_RELEASE, "R7 busy-high after store", len, T_RELEASE);
    quiet_window("R10 R11 no queued store, inhibited write ignored", 12);

    // R11 write in busy-high phase is accepted
    pulse_write();
    pulse_req();
    run_len(2, len);
    run_len(1, len);
    check(len == T_STORE, "R3 second store length", len, T_STORE);
    check(probe(3), "R7 busy-high entered", busy_n, 1);
    pulse_write();
    run_len(3, len);
    check(len == T_RELEASE - 1, "R7 rest of busy-high", len, T_RELEASE - 1);
    pulse_req();
    check(probe(2), "R11 write in busy-high sets dirty", store_active, 0);
    run_len(2, len);
    run_len(1, len);
    check(len == T_STORE, "R11 store after busy-high write", len, T_STORE);
    run_len(3, len);

    // R9 brown-out while dirty
    pulse_write();
    supply_ok = 1'b0;
    #1;
    check(access_inhibit == 1'b1, "R6 supply low in idle", access_inhibit, 1);
    @(negedge clk);
    check(access_inhibit == 1'b0, "R4 grace open with supply low", access_inhibit, 0);
    run_len(2, len);
    check(len == T_GRACE, "R9 grace length on drop", len, T_GRACE);
    run_len(1, len);
    check(len == T_STORE, "R9 auto store length", len, T_STORE);
    check(probe(4), "R9 power-low after auto store", {busy_drive, busy_n}, 2'b10);
    supply_ok = 1'b1;
    @(negedge clk);
    run_len(0, len);
    check(len == T_RECALL, "R9 recall after brown-out", len, T_RECALL);
    run_len(3, len);
    check(len == T_RELEASE, "R7 busy-high after brown-out", len, T_RELEASE);

    // R5 clean drop goes straight to power-low
    supply_ok = 1'b0;
    @(negedge clk);
    check(probe(4), "R5 clean drop to power-low", {busy_drive, busy_n}, 2'b10);
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 8; i++) begin
        if (store_active || recall_active) seen++;
        @(negedge clk);
      end
      check(seen == 0, "R5 no store on clean drop", seen, 0);
    end
    supply_ok = 1'b1;
    @(negedge clk);
    run_len(0, len);
    check(len == T_RECALL, "R2 recall after clean drop", len, T_RECALL);
    run_len(3, len);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule